// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles the even parity line of a 32-bit multiplexed address/data bus that has four command/byte-enable lines. A bus controller tells it, cycle by cycle, when an address phase or a completed data phase is on the bus, and whether the device is currently the initiator or the responder and whether the transfer is a write. From that it produces the parity bit and a drive enable one clock after every phase the device itself sources. It also compares the incoming parity bit against a locally computed value for phases that another agent sources.

A data parity mismatch seen as responder on a write raises a data-error flag. An address parity mismatch seen as responder raises a one-clock system-error pulse. Each report has its own enable input, which stands in for a command-register bit. Outputs are active high; the pad logic supplies any inversion or open-drain behaviour.

Top module: `pci_parity_unit`

## Requirements
- R1: The generated parity bit equals the XOR of all 32 address/data bits and all 4 command/byte-enable bits, so that the 37 bits together hold an even number of ones. Byte-enable bits count even when they mark a lane as unused.
- R2: The parity for a phase sampled at clock edge N is presented on `par_out` during the cycle that follows edge N, and is sampled by the far end at edge N+1.
- R3: `par_drv` is high in the cycle after exactly these phases: an address phase while initiator; a data phase while initiator on a write; a data phase while responder on a read (`dir_wr`=0). It is low after every other cycle.
- R4: While `rst_n` is low, `par_drv`, `perr_flag` and `serr_flag` are low, whatever the other inputs do.
- R5: For a data phase completed at edge N as responder on a write, `par_in` is compared at edge N+1. A mismatch drives `perr_flag` high for the single cycle after edge N+1. Consecutive failing phases give one high cycle each.
- R6: Data phases as initiator, and data phases as responder on a read, never raise `perr_flag`, even when `par_in` mismatches.
- R7: For an address phase sampled at edge N as responder, a mismatch of `par_in` at edge N+1 drives `serr_flag` high for exactly the cycle after edge N+1. Address phases as initiator are not checked.
- R8: `perr_flag` reports only when `perr_rpt_en` is high at the compare edge, and `serr_flag` reports only when `serr_rpt_en` is high at the compare edge.
- R9: Cycles with neither `adr_ph` nor `dat_ph` high (idle or wait states) cause no drive and no error report, whatever `par_in` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 32 | Multiplexed address/data value on the bus |
| bus_cbe | input | 4 | Command/byte-enable lines |
| par_in | input | 1 | Parity bit as seen on the bus |
| adr_ph | input | 1 | An address phase is on the bus this cycle |
| dat_ph | input | 1 | A data phase completes this cycle |
| role_mst | input | 1 | 1 = device is initiator, 0 = responder |
| dir_wr | input | 1 | 1 = write transfer, 0 = read transfer |
| perr_rpt_en | input | 1 | Enables data-error reporting |
| serr_rpt_en | input | 1 | Enables address-error reporting |
| par_out | output | 1 | Generated parity bit |
| par_drv | output | 1 | Drive enable for the parity pad |
| perr_flag | output | 1 | Data parity error, active high |
| serr_flag | output | 1 | Address parity error pulse, active high |

## Verification
A wrong captured parity shows on `par_out` in the very next cycle, and a wrong role or direction decode shows as a misplaced `par_drv` in that same cycle. A stale expected value or a lost check qualifier shows one cycle later still, as a missing, extra or stretched `perr_flag` or `serr_flag` two cycles after the phase. The bench therefore samples every cycle of each burst, including wait states, so that a fault cannot hide behind a later phase.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  bus_ad,
  input  logic [CBE_W-1:0] bus_cbe,
  input  logic             par_in,
  input  logic             adr_ph,
  input  logic             dat_ph,
  input  logic             role_mst,
  input  logic             dir_wr,
  input  logic             perr_rpt_en,
  input  logic             serr_rpt_en,
  output logic             par_out,
  output logic             par_drv,
  output logic             perr_flag,
  output logic             serr_flag
);

  logic calc, drive_now, chk_adr_now, chk_dat_now;
  logic exp_q, chk_adr_q, chk_dat_q, miss;

  assign calc        = ^{bus_ad, bus_cbe};
  assign drive_now   = (adr_ph & role_mst) | (dat_ph & (role_mst == dir_wr));
  assign chk_adr_now = adr_ph & ~role_mst;
  assign chk_dat_now = dat_ph & ~role_mst & dir_wr;
  assign miss        = exp_q ^ par_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out   <= 1'b0;
      par_drv   <= 1'b0;
      exp_q     <= 1'b0;
      chk_adr_q <= 1'b0;
      chk_dat_q <= 1'b0;
      perr_flag <= 1'b0;
      serr_flag <= 1'b0;
    end else begin
      par_out   <= calc;
      par_drv   <= drive_now;
      exp_q     <= calc;
      chk_adr_q <= chk_adr_now;
      chk_dat_q <= chk_dat_now;
      perr_flag <= chk_dat_q & miss & perr_rpt_en;
      serr_flag <= chk_adr_q & miss & serr_rpt_en;
    end
  end

endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AD_W-1:0]  bus_ad,
  input logic [CBE_W-1:0] bus_cbe,
  input logic             adr_ph,
  input logic             dat_ph,
  input logic             role_mst,
  input logic             dir_wr,
  input logic             perr_rpt_en,
  input logic             serr_rpt_en,
  input logic             par_out,
  input logic             par_drv,
  input logic             perr_flag,
  input logic             serr_flag
);

  assert_par_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    par_drv |-> (par_out == $past(^{bus_ad, bus_cbe})));

  assert_drive_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    par_drv |-> $past((adr_ph & role_mst) | (dat_ph & (role_mst == dir_wr))));

  assert_perr_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    perr_flag |-> $past(dat_ph & ~role_mst & dir_wr, 2));

  assert_serr_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    serr_flag |-> $past(adr_ph & ~role_mst, 2));

  assert_perr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    perr_flag |-> $past(perr_rpt_en));

  assert_serr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_flag |-> $past(serr_rpt_en));

endmodule

bind pci_parity_unit pci_parity_unit_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe(bus_cbe),
  .adr_ph(adr_ph), .dat_ph(dat_ph), .role_mst(role_mst), .dir_wr(dir_wr),
  .perr_rpt_en(perr_rpt_en), .serr_rpt_en(serr_rpt_en),
  .par_out(par_out), .par_drv(par_drv), .perr_flag(perr_flag), .serr_flag(serr_flag)
);

// File: tb/tb_pci_parity_unit.sv
module tb_pci_parity_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_cbe = '0;
  logic par_in = 1'b0, adr_ph = 1'b0, dat_ph = 1'b0, role_mst = 1'b0, dir_wr = 1'b0;
  logic perr_rpt_en = 1'b1, serr_rpt_en = 1'b1;
  logic par_out, par_drv, perr_flag, serr_flag;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pci_parity_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe(bus_cbe), .par_in(par_in),
    .adr_ph(adr_ph), .dat_ph(dat_ph), .role_mst(role_mst), .dir_wr(dir_wr),
    .perr_rpt_en(perr_rpt_en), .serr_rpt_en(serr_rpt_en),
    .par_out(par_out), .par_drv(par_drv), .perr_flag(perr_flag), .serr_flag(serr_flag)
  );

  logic [31:0] ph_ad [16];
  logic [3:0]  ph_cbe[16];
  logic        ph_v[16], ph_a[16], ph_m[16], ph_w[16], ph_c[16], ph_p[16];
  string tag_v, tag_o, tag_p, tag_s;

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic even_bit(input logic [31:0] a, input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) n += a[i];
    for (int i = 0; i < 4; i++) n += c[i];
    return (n % 2) == 1;
  endfunction

  task automatic set_ph(input int k, input logic v, input logic a, input logic m,
                        input logic w, input logic c, input logic [31:0] d, input logic [3:0] e);
    ph_v[k] = v; ph_a[k] = a; ph_m[k] = m; ph_w[k] = w; ph_c[k] = c;
    ph_ad[k] = d; ph_cbe[k] = e; ph_p[k] = even_bit(d, e);
  endtask

  task automatic run_burst(input int n, input logic pe, input logic se);
    perr_rpt_en = pe;
    serr_rpt_en = se;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 1 && i - 1 < n) begin
        int j = i - 1;
        logic e_oe = ph_v[j] && ((ph_a[j] && ph_m[j]) || (!ph_a[j] && (ph_m[j] == ph_w[j])));
        check(tag_o, par_drv, e_oe);
        if (e_oe) check(tag_v, par_out, ph_p[j]);
      end
      if (i >= 2) begin
        int j = i - 2;
        logic e_pe = ph_v[j] && !ph_a[j] && !ph_m[j] && ph_w[j] && ph_c[j] && pe;
        logic e_se = ph_v[j] && ph_a[j] && !ph_m[j] && ph_c[j] && se;
        check(tag_p, perr_flag, e_pe);
        check(tag_s, serr_flag, e_se);
      end
      if (i < n) begin
        bus_ad = ph_ad[i]; bus_cbe = ph_cbe[i];
        adr_ph = ph_v[i] && ph_a[i]; dat_ph = ph_v[i] && !ph_a[i];
        role_mst = ph_m[i]; dir_wr = ph_w[i];
      end else begin
        bus_ad = 32'hDEAD_BEEF; bus_cbe = 4'h5;
        adr_ph = 1'b0; dat_ph = 1'b0;
      end
      par_in = (i >= 1 && i - 1 < n) ? (ph_p[i-1] ^ ph_c[i-1]) : 1'b0;
    end
    @(negedge clk);
    par_in = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R4: reset holds outputs low while qualifying inputs are applied
    bus_ad = 32'h0000_0001; adr_ph = 1'b1; dat_ph = 1'b1; role_mst = 1'b1; dir_wr = 1'b1;
    par_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4", par_drv, 1'b0);
      check("R4", perr_flag, 1'b0);
      check("R4", serr_flag, 1'b0);
    end
    adr_ph = 1'b0; dat_ph = 1'b0; par_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1: walking single bit over all 36 covered bits, plus all-zero and all-ones lanes off
    tag_v = "R1"; tag_o = "R3"; tag_p = "R6"; tag_s = "R7";
    for (int b = 0; b < 38; b++) begin
      logic [31:0] d = (b < 32) ? (32'h1 << b) : 32'h0;
      logic [3:0]  e = (b >= 32 && b < 36) ? (4'h1 << (b - 32)) : ((b == 37) ? 4'hF : 4'h0);
      set_ph(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, d, e);
      set_ph(1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, d ^ 32'h0000_0300, e);
      run_burst(2, 1'b1, 1'b1);
    end

    // R3 R5 R6 R7: every kind/role/direction with clean and corrupt parity
    tag_v = "R2"; tag_o = "R3";
    for (int k = 0; k < 16; k++) begin
      logic a = k[3], m = k[2], w = k[1], c = k[0];
      tag_p = (!a && !m && w) ? "R5" : "R6";
      tag_s = "R7";
      set_ph(0, 1'b1, a, m, w, c, 32'hA5C3_0F17 + 32'(k * 32'h0101_1113), 4'(k));
      run_burst(1, 1'b1, 1'b1);
    end

    // R5 R9: responder write burst with wait states and scattered errors
    tag_v = "R2"; tag_o = "R9"; tag_p = "R5"; tag_s = "R9";
    set_ph(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h1000_0040, 4'b0111);
    for (int k = 1; k < 14; k++) begin
      logic v = (k % 4) != 3;
      logic c = (k == 2) || (k == 3) || (k == 4) || (k == 7) || (k == 11) || (k == 12);
      set_ph(k, v, 1'b0, 1'b0, 1'b1, c, 32'h3C00_0000 ^ 32'(k * 32'h0007_0301), 4'(k));
    end
    run_burst(14, 1'b1, 1'b1);

    // R9: idle cycles with bad parity only
    tag_o = "R9"; tag_p = "R9"; tag_s = "R9";
    for (int k = 0; k < 6; k++) set_ph(k, 1'b0, k[0], 1'b0, 1'b1, 1'b1, 32'hFFFF_0000, 4'hA);
    run_burst(6, 1'b1, 1'b1);

    // R8: reporting enables low suppress both flags
    tag_v = "R2"; tag_o = "R3"; tag_p = "R8"; tag_s = "R8";
    set_ph(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_8000, 4'h7);
    set_ph(1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1234_5678, 4'h0);
    set_ph(2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8765_4321, 4'hF);
    run_burst(3, 1'b0, 1'b0);
    run_burst(3, 1'b0, 1'b1);
    run_burst(3, 1'b1, 1'b0);

    // R7: back-to-back responder address errors give separate pulses
    tag_p = "R6"; tag_s = "R7";
    set_ph(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0004, 4'h6);
    set_ph(1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0008, 4'h7);
    set_ph(2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_000C, 4'h6);
    set_ph(3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0010, 4'h6);
    run_burst(4, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule